// File: doc/BRIEF.md
# Three-Channel Timer Host Register Interface

This block is the byte-wide programming front end for a group of three interval-timer channels. A host reaches it through four addresses. Addresses 0 to 2 are the count ports of channels 0 to 2, and address 3 accepts control words. Control words set each channel's byte access pattern, its operating mode and its decimal-count flag. They also freeze a copy of a channel's count, or of a status byte, so that a later read returns a value that does not change underneath it.

Count writes are assembled into 16-bit reload values. Each value is handed to the counter logic on a one-cycle load strobe, together with the channel's mode and decimal flag. Reads return one byte at a time, taken from a pending status snapshot, a pending count snapshot or the live count, in that order of preference. The counters themselves sit outside the block. They supply the live count and the output level of each channel.

Top module: `tmr_host_regs`

## Requirements
- R1: After reset every channel reports mode 0 and decimal flag 0, no load strobe is raised, and the access pattern is low byte then high byte.
- R2: A write to address 3 whose bits 7:6 name channel 0, 1 or 2 and whose bits 5:4 are nonzero stores bits 5:4 as the access pattern (1 low only, 2 high only, 3 low then high), bits 3:1 as the mode and bit 0 as the decimal flag. Mode and flag outputs change one cycle after the write. The mode does not change in any cycle that follows a cycle with no control write.
- R3: Mode codes 6 and 7 are stored and reported as 2 and 3, so the reported mode never exceeds 5.
- R4: In low-only access a count write loads {8'h00, byte}, and in high-only access it loads {byte, 8'h00}. The load strobe of that channel is high for the single cycle after the write and is never high without a count write to that channel in the previous cycle.
- R5: In low-then-high access the first count write raises no strobe. The second write loads {second, first}.
- R6: With nothing latched, a count read returns the low byte of the live count in low-only access and the high byte in high-only access. In low-then-high access it alternates low, high, low and so on.
- R7: A control word with bits 5:4 equal to 0 snapshots the channel's live count. Subsequent reads return that snapshot's bytes in the access order (one byte, or low then high), after which reads return live bytes again.
- R8: A control word with bits 7:6 equal to 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. For each selected channel, bit 5 low snapshots the count and bit 4 low snapshots the status.
- R9: A status byte carries the output level in bit 7, 0 in bit 6, the access pattern in bits 5:4, the mode in bits 3:1 and the decimal flag in bit 0, all captured when the snapshot is taken.
- R10: A count snapshot request is ignored while a count snapshot of that channel is still unread. A status snapshot request is ignored while a status snapshot is still unread.
- R11: A read returns a pending status byte first and clears it. Next it returns pending count snapshot bytes, and only then live bytes. A read of address 3 returns 8'h00 and changes nothing.
- R12: Any control word that sets a channel's configuration restarts both its read and its write byte order at the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle; side effects at the clock edge |
| addr | input | 2 | 0 to 2 count ports, 3 control port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid in the cycle rd_en is high |
| ch_count | input | 48 | Live 16-bit count of each channel, channel c at bits 16c+15:16c |
| ch_out | input | 3 | Output level of each channel |
| ld_stb | output | 3 | One-cycle load strobe per channel |
| ld_val | output | 48 | 16-bit reload value per channel, valid with ld_stb |
| ch_mode | output | 9 | 3-bit mode per channel, channel c at bits 3c+2:3c |
| ch_bcd | output | 3 | Decimal count flag per channel |

## Verification
The properties assume the host never asserts read and write in the same cycle, so a byte pointer or a snapshot is never advanced and reloaded at the same edge. The stimulus drives each host access as a single-cycle pulse with an idle gap before the next one. A property also checks that this assumption holds. The properties also take the live counts and output levels as arbitrary. The stimulus changes those inputs between a snapshot and its read, so that a snapshot that follows the live value can be told apart from one that holds.

// File: rtl/tmr_regs_pkg.sv
package tmr_regs_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_LH   = 2'd3
  } acc_e;

  // Codes 6 and 7 alias the periodic modes 2 and 3.
  function automatic logic [2:0] fold_mode(input logic [2:0] m);
    return (m > 3'd5) ? (m - 3'd4) : m;
  endfunction

  function automatic logic [7:0] status_byte(input logic out_lvl, input acc_e acc,
                                             input logic [2:0] mode, input logic bcd);
    return {out_lvl, 1'b0, 2'(acc), mode, bcd};
  endfunction

  function automatic logic [7:0] pick_byte(input logic [15:0] v, input logic hi);
    return hi ? v[15:8] : v[7:0];
  endfunction

endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
  import tmr_regs_pkg::*;
#(
  parameter int CH_N = 3
) (
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [7:0]      wdata,
  output logic [CH_N-1:0] cfg_we,
  output logic [CH_N-1:0] lat_cnt,
  output logic [CH_N-1:0] lat_sts,
  output acc_e            cfg_acc,
  output logic [2:0]      cfg_mode,
  output logic            cfg_bcd
);
  logic       ctl_wr;
  logic       is_rb;
  logic [1:0] sel;

  assign ctl_wr   = wr_en && (addr == 2'd3);
  assign sel      = wdata[7:6];
  assign is_rb    = (sel == 2'd3);
  assign cfg_acc  = acc_e'(wdata[5:4]);
  assign cfg_mode = fold_mode(wdata[3:1]);
  assign cfg_bcd  = wdata[0];

  always_comb begin
    cfg_we  = '0;
    lat_cnt = '0;
    lat_sts = '0;
    for (int c = 0; c < CH_N; c++) begin
      if (ctl_wr && is_rb) begin
        if (wdata[c+1]) begin
          lat_cnt[c] = !wdata[5];
          lat_sts[c] = !wdata[4];
        end
      end else if (ctl_wr && sel == 2'(c)) begin
        if (cfg_acc == ACC_NONE) lat_cnt[c] = 1'b1;
        else                     cfg_we[c]  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_regs_pkg::*;
#(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  acc_e          cfg_acc,
  input  logic [2:0]    cfg_mode,
  input  logic          cfg_bcd,
  input  logic          lat_cnt,
  input  logic          lat_sts,
  input  logic          wr_hit,
  input  logic          rd_hit,
  input  logic [BW-1:0] wdata,
  input  logic [CW-1:0] live_cnt,
  input  logic          out_lvl,
  output logic [BW-1:0] rd_byte,
  output logic          rd_is_sts,
  output logic          ld_stb,
  output logic [CW-1:0] ld_val,
  output logic [2:0]    mode,
  output logic          bcd
);
  acc_e          acc, pend;
  logic          wr_hi, rd_hi, sts_v;
  logic [BW-1:0] hold, sts;
  logic [CW-1:0] snap;

  always_comb begin
    rd_is_sts = sts_v;
    if (sts_v) rd_byte = sts;
    else begin
      case (pend)
        ACC_LO, ACC_LH: rd_byte = pick_byte(snap, 1'b0);
        ACC_HI:         rd_byte = pick_byte(snap, 1'b1);
        default: begin
          case (acc)
            ACC_HI:  rd_byte = pick_byte(live_cnt, 1'b1);
            ACC_LH:  rd_byte = pick_byte(live_cnt, rd_hi);
            default: rd_byte = pick_byte(live_cnt, 1'b0);
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= ACC_LH;
      pend   <= ACC_NONE;
      mode   <= '0;
      bcd    <= 1'b0;
      wr_hi  <= 1'b0;
      rd_hi  <= 1'b0;
      sts_v  <= 1'b0;
      sts    <= '0;
      hold   <= '0;
      snap   <= '0;
      ld_stb <= 1'b0;
      ld_val <= '0;
    end else begin
      ld_stb <= 1'b0;
      if (cfg_we) begin
        acc   <= cfg_acc;
        mode  <= cfg_mode;
        bcd   <= cfg_bcd;
        wr_hi <= 1'b0;
        rd_hi <= 1'b0;
      end
      if (lat_cnt && pend == ACC_NONE) begin
        snap <= live_cnt;
        pend <= acc;
      end
      if (lat_sts && !sts_v) begin
        sts_v <= 1'b1;
        sts   <= status_byte(out_lvl, acc, mode, bcd);
      end
      if (wr_hit) begin
        case (acc)
          ACC_HI: begin
            ld_stb <= 1'b1;
            ld_val <= {wdata, {BW{1'b0}}};
          end
          ACC_LH: begin
            if (!wr_hi) hold <= wdata;
            else begin
              ld_stb <= 1'b1;
              ld_val <= {wdata, hold};
            end
            wr_hi <= !wr_hi;
          end
          default: begin
            ld_stb <= 1'b1;
            ld_val <= {{BW{1'b0}}, wdata};
          end
        endcase
      end
      if (rd_hit) begin
        if (sts_v) sts_v <= 1'b0;
        else if (pend != ACC_NONE) pend <= (pend == ACC_LH) ? ACC_HI : ACC_NONE;
        else if (acc == ACC_LH) rd_hi <= !rd_hi;
      end
    end
  end
endmodule

// File: rtl/tmr_host_regs.sv
module tmr_host_regs
  import tmr_regs_pkg::*;
#(
  parameter int CH_N = 3,
  parameter int BW   = 8,
  localparam int CW  = 2 * BW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [BW-1:0]    wdata,
  output logic [BW-1:0]    rdata,
  input  logic [CH_N*CW-1:0] ch_count,
  input  logic [CH_N-1:0]  ch_out,
  output logic [CH_N-1:0]  ld_stb,
  output logic [CH_N*CW-1:0] ld_val,
  output logic [CH_N*3-1:0] ch_mode,
  output logic [CH_N-1:0]  ch_bcd
);
  logic [CH_N-1:0] cfg_we, lat_cnt, lat_sts, rd_sts_v;
  acc_e            cfg_acc;
  logic [2:0]      cfg_mode;
  logic            cfg_bcd;
  logic [BW-1:0]   rd_byte [CH_N];
  logic            rd_is_status;

  tmr_ctl_decode #(.CH_N(CH_N)) u_dec (
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cfg_we(cfg_we), .lat_cnt(lat_cnt), .lat_sts(lat_sts),
    .cfg_acc(cfg_acc), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    tmr_chan_regs #(.BW(BW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we[c]), .cfg_acc(cfg_acc), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd),
      .lat_cnt(lat_cnt[c]), .lat_sts(lat_sts[c]),
      .wr_hit(wr_en && addr == 2'(c)), .rd_hit(rd_en && addr == 2'(c)),
      .wdata(wdata), .live_cnt(ch_count[c*CW +: CW]), .out_lvl(ch_out[c]),
      .rd_byte(rd_byte[c]), .rd_is_sts(rd_sts_v[c]),
      .ld_stb(ld_stb[c]), .ld_val(ld_val[c*CW +: CW]),
      .mode(ch_mode[c*3 +: 3]), .bcd(ch_bcd[c])
    );
  end

  always_comb begin
    rdata        = '0;
    rd_is_status = 1'b0;
    for (int c = 0; c < CH_N; c++) begin
      if (addr == 2'(c)) begin
        rdata        = rd_byte[c];
        rd_is_status = rd_sts_v[c];
      end
    end
  end
endmodule

// File: rtl/tmr_host_regs_chk.sv
module tmr_host_regs_chk #(
  parameter int CH_N = 3,
  parameter int BW   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        addr,
  input logic [BW-1:0]     rdata,
  input logic              rd_is_status,
  input logic [CH_N-1:0]   ld_stb,
  input logic [CH_N*3-1:0] ch_mode
);
  p_single_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));

  p_status_bit6_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_is_status) |-> (rdata[6] == 1'b0));

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 2'd3) |=> $stable(ch_mode));

  for (genvar c = 0; c < CH_N; c++) begin : g_chk
    p_load_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stb[c] |-> $past(wr_en && addr == 2'(c)));

    p_mode_fold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ch_mode[c*3 +: 3] <= 3'd5);
  end
endmodule

bind tmr_host_regs tmr_host_regs_chk #(.CH_N(CH_N), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .rd_is_status(rd_is_status), .ld_stb(ld_stb), .ch_mode(ch_mode)
);

// File: tb/sim_tmr_host_regs.sv
module sim_tmr_host_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] ch_count = '0;
  logic [2:0]  ch_out = '0;
  logic [2:0]  ld_stb;
  logic [47:0] ld_val;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference state
  int m_acc [3], m_mode [3], m_bcd [3], m_wt [3], m_rt [3], m_hold [3];
  int m_sv [3], m_sts [3];
  int cq [3][$];
  int exp_stb [3], exp_val [3];

  always #2 clk = ~clk;

  tmr_host_regs u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ch_count(ch_count), .ch_out(ch_out),
    .ld_stb(ld_stb), .ld_val(ld_val), .ch_mode(ch_mode), .ch_bcd(ch_bcd)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int live(input int c);
    return int'(ch_count[c*16 +: 16]);
  endfunction

  function automatic void m_latch_cnt(input int c);
    int v;
    v = live(c);
    if (cq[c].size() != 0) return;
    if (m_acc[c] == 1) cq[c].push_back(v % 256);
    else if (m_acc[c] == 2) cq[c].push_back(v / 256);
    else begin cq[c].push_back(v % 256); cq[c].push_back(v / 256); end
  endfunction

  function automatic void m_write(input int a, input int d);
    int sel, ac, md;
    for (int c = 0; c < 3; c++) exp_stb[c] = 0;
    if (a == 3) begin
      sel = d / 64;
      ac = (d / 16) % 4;
      if (sel == 3) begin
        for (int c = 0; c < 3; c++)
          if (d[c+1]) begin
            if (!d[5]) m_latch_cnt(c);
            if (!d[4] && m_sv[c] == 0) begin
              m_sv[c] = 1;
              m_sts[c] = ch_out[c] * 128 + m_acc[c] * 16 + m_mode[c] * 2 + m_bcd[c];
            end
          end
      end else if (ac == 0) m_latch_cnt(sel);
      else begin
        md = (d / 2) % 8;
        if (md >= 6) md -= 4;
        m_acc[sel] = ac; m_mode[sel] = md; m_bcd[sel] = d % 2;
        m_wt[sel] = 0; m_rt[sel] = 0;
      end
    end else begin
      if (m_acc[a] == 1) begin exp_stb[a] = 1; exp_val[a] = d; end
      else if (m_acc[a] == 2) begin exp_stb[a] = 1; exp_val[a] = d * 256; end
      else if (m_wt[a] == 0) begin m_hold[a] = d; m_wt[a] = 1; end
      else begin exp_stb[a] = 1; exp_val[a] = d * 256 + m_hold[a]; m_wt[a] = 0; end
    end
  endfunction

  function automatic int m_read(input int a);
    int v;
    if (a == 3) return 0;
    if (m_sv[a] != 0) begin m_sv[a] = 0; return m_sts[a]; end
    if (cq[a].size() != 0) return cq[a].pop_front();
    v = live(a);
    if (m_acc[a] == 1) return v % 256;
    if (m_acc[a] == 2) return v / 256;
    m_rt[a] = 1 - m_rt[a];
    return (m_rt[a] == 1) ? v % 256 : v / 256;
  endfunction

  // One clock: drive at a falling edge, compare outputs at the next falling edge.
  task automatic op(input bit w, input bit r, input int a, input int d, input string tag);
    int e;
    wr_en = w; rd_en = r; addr = 2'(a); wdata = 8'(d);
    #1;
    if (r) begin
      e = m_read(a);
      chk(int'(rdata) == e, tag, "rdata", int'(rdata), e);
    end
    if (w) m_write(a, d);
    else for (int c = 0; c < 3; c++) exp_stb[c] = 0;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    for (int c = 0; c < 3; c++) begin
      chk(int'(ld_stb[c]) == exp_stb[c], tag, "ld_stb", int'(ld_stb[c]), exp_stb[c]);
      if (exp_stb[c] != 0)
        chk(int'(ld_val[c*16 +: 16]) == exp_val[c], tag, "ld_val", int'(ld_val[c*16 +: 16]), exp_val[c]);
      chk(int'(ch_mode[c*3 +: 3]) == m_mode[c], tag, "mode", int'(ch_mode[c*3 +: 3]), m_mode[c]);
      chk(int'(ch_bcd[c]) == m_bcd[c], tag, "bcd", int'(ch_bcd[c]), m_bcd[c]);
    end
  endtask

  task automatic wr(input int a, input int d, input string tag);
    op(1, 0, a, d, tag);
    op(0, 0, 0, 0, tag);
  endtask

  task automatic rd(input int a, input string tag);
    op(0, 1, a, 0, tag);
    op(0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 3; c++) begin
      m_acc[c] = 3; m_mode[c] = 0; m_bcd[c] = 0; m_wt[c] = 0; m_rt[c] = 0;
      m_hold[c] = 0; m_sv[c] = 0; m_sts[c] = 0; exp_stb[c] = 0; exp_val[c] = 0;
    end
    ch_count = {16'hC3C2, 16'hB2B1, 16'hA2A1};
    ch_out = 3'b101;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset outputs and default low-then-high read order
    op(0, 0, 0, 0, "R1");
    rd(0, "R1"); rd(0, "R1");
    // R2: channel 0, low only, mode 2, decimal flag set
    wr(3, 8'h15, "R2");
    // R4: low-only load
    wr(0, 8'h34, "R4");
    // R3: mode 7 folds to 3; channel 1 high only
    wr(3, 8'h6E, "R3");
    wr(1, 8'hAB, "R4");
    // R3: mode 6 folds to 2; channel 2 low then high
    wr(3, 8'hBC, "R3");
    // R5: paired write
    wr(2, 8'h11, "R5"); wr(2, 8'h22, "R5");
    // R6: live reads in each access pattern
    rd(0, "R6"); rd(1, "R6"); rd(2, "R6"); rd(2, "R6"); rd(2, "R6");
    rd(2, "R6");
    // R7: count snapshot on channel 2 holds while live moves
    wr(3, 8'h80, "R7");
    ch_count[32 +: 16] = 16'h5566;
    rd(2, "R7"); rd(2, "R7"); rd(2, "R7"); rd(2, "R7");
    // R10: second count snapshot while one unread is ignored
    wr(3, 8'h80, "R10");
    ch_count[32 +: 16] = 16'h7788;
    wr(3, 8'h80, "R10");
    rd(2, "R10"); rd(2, "R10");
    // R8 / R9 / R11: read-back count and status of all channels
    ch_out = 3'b011;
    wr(3, 8'hCE, "R8");
    ch_count = {16'h1234, 16'h4567, 16'h89AB};
    rd(0, "R11"); rd(0, "R11"); rd(0, "R11");
    rd(1, "R9"); rd(1, "R9");
    rd(2, "R9"); rd(2, "R8"); rd(2, "R8"); rd(2, "R8");
    // R10: status snapshot request ignored while one unread
    wr(3, 8'hE4, "R10");
    ch_out = 3'b000;
    wr(3, 8'hE4, "R10");
    rd(1, "R10"); rd(1, "R10");
    // R8: only bit 2 selects channel 1; channel 0 status is not taken
    wr(3, 8'hE4, "R8");
    rd(0, "R8"); rd(1, "R8");
    // R11: address 3 reads as zero without side effects
    rd(3, "R11"); rd(2, "R11");
    // R12: a new control word restarts both byte orders
    wr(2, 8'h99, "R12");
    rd(2, "R12");
    wr(3, 8'hB0, "R12");
    rd(2, "R12");
    wr(2, 8'h0F, "R12"); wr(2, 8'hF0, "R12");
    rd(2, "R12");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule